// File: doc/BRIEF.md
# Stack-based calculator entry controller

This block sits between a decoded keyboard and an arithmetic unit. It builds unsigned byte operands from decimal key presses, holds an operator chosen from a small key set, and writes each finished entry into an external byte-wide single-port RAM when the latch strobe arrives. The RAM is used as a stack. Operator entries share the same byte space as numbers through a band of reserved codes.

When Enter is pressed, the controller pops one complete operation off the top of the stack. It reads the entries back one at a time, allowing for the RAM's one-cycle read latency. It then presents operand A, operand B and the operator code to the arithmetic unit with a one-cycle valid strobe.

A binary operation takes three entries from the stack. A modulo-3 operation takes two. A pop that finds too few entries raises a one-cycle error strobe instead of the valid strobe. New entries may be pushed at any time between pops, and later pops continue from the current top.

Top module: `calc_entry_stack`

## Requirements
- R1: While reset is active and after it ends, the stack is empty, `aluOpA`, `aluOpB` and `aluOp` are 0, and `aluValid`, `popError` and `ramWe` are low.
- R2: Digit keys build the pending number as value*10+digit and saturate at 255, so typing 1,2,3,4 gives 255 and typing 0,9 gives 9. A digit key above 9 has no effect. A digit typed while an operator is pending starts a new number.
- R3: Operator key selection s in 0..5 makes the pending entry the operator code 130+s. The codes are 130 add, 131 subtract, 132 multiply, 133 modulo 3, and 134 and 135 further two-operand operators. Selections 6 and 7 have no effect. A pending number in 130..135 is not written on latch and remains pending.
- R4: Backspace discards the pending entry. A latch with no pending entry writes nothing.
- R5: A latch in idle writes the pending byte with `ramWe` high for one cycle at `ramAddr` equal to the current entry count, then increments the count and clears the pending entry. When the count equals 2^AW, latches are ignored.
- R6: When Enter finds a non-133 byte on top and at least three entries, `aluValid` is high for exactly one cycle, in the cycle after the sixth rising edge following the edge that sampled Enter. At that point B is the top entry, the operator is the entry below it, and A is the entry below that. The count drops by 3.
- R7: When the top entry is 133 and the count is at least 2, the pop ends after the fourth edge with A set to the entry below, the operator 133 and B 0. The count drops by 2.
- R8: When entries are too few, `popError` pulses for one cycle and `aluValid` stays low with the count unchanged. On an empty stack the pulse follows the Enter edge. Otherwise it follows the second edge after it.
- R9: During a pop, reads use `ramWe` low and addresses count-1, count-2 and count-3 in order. Each address is held for one cycle, and its data is taken in the following cycle.
- R10: While a pop is in progress, latch and Enter are ignored, but digit, operator and backspace keys still edit the pending entry. In idle, Enter takes priority over a simultaneous latch.
- R11: Entries pushed after earlier pops are written starting at the current count, and later pops take them from the top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyDigitValid | input | 1 | Digit key strobe |
| keyDigit | input | 4 | Digit value |
| keyOpValid | input | 1 | Operator key strobe |
| keyOpSel | input | 3 | Operator selection, code 130+sel |
| keyBackspace | input | 1 | Discard pending entry |
| latchPulse | input | 1 | Push pending entry |
| enterPulse | input | 1 | Pop one operation |
| ramAddr | output | AW | RAM address |
| ramWData | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRData | input | 8 | RAM read data, one cycle after address |
| aluValid | output | 1 | One-cycle operation strobe |
| aluOpA | output | 8 | Operand A |
| aluOpB | output | 8 | Operand B (0 for modulo 3) |
| aluOp | output | 8 | Operator code |
| popError | output | 1 | One-cycle too-few-entries strobe |

## Verification
The stack is driven through several kinds of sequence:
- Ordinary three-entry operations.
- A modulo-3 pair.
- Pops on an empty stack, on a lone operand, on a lone modulo code, and on two entries whose top is an operand. These separate the count checks for the two pop lengths.
- Saturating entry (1234) and a rejected reserved number (132). These separate clamping from code filtering.
- Latch and Enter pressed during a pop, and together in idle. These show that busy and priority handling do not leak writes.

A push after several pops and a fill to capacity show that the write address tracks the live count rather than a history.

// File: rtl/calc_entry_pkg.sv
package calc_entry_pkg;

  localparam int OP_FIRST = 130;
  localparam int OP_LAST  = 135;
  localparam int OP_MOD3  = 133;
  localparam int OP_KEYS  = OP_LAST - OP_FIRST + 1;

  typedef enum logic [1:0] {
    ENT_EMPTY,
    ENT_NUM,
    ENT_OP
  } entKind_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ISSUE,
    SEQ_CAPTURE
  } seqState_t;

  typedef struct packed {
    logic       pushEntry;
    logic       readActive;
    logic [1:0] readIdx;
    logic       capture;
    logic       commitPop;
    logic       commitMod;
    logic       popFail;
  } ctlStrobe_t;

endpackage

// File: rtl/calc_entry_ctrl.sv
module calc_entry_ctrl
  import calc_entry_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         latchPulse,
  input  logic         enterPulse,
  input  logic [7:0]   ramRData,
  input  logic [AW:0]  stackCount,
  input  logic         entryOk,
  output ctlStrobe_t   ctl
);

  localparam logic [AW:0] CNT_ZERO  = '0;
  localparam logic [AW:0] CNT_TWO   = (AW+1)'(2);
  localparam logic [AW:0] CNT_THREE = (AW+1)'(3);

  seqState_t state, stateNext;
  logic [1:0] rdIdx, rdIdxNext;
  logic modReg, modNext;
  logic topIsMod;

  assign topIsMod = (ramRData == 8'(OP_MOD3));

  always_comb begin
    ctl       = '0;
    stateNext = state;
    rdIdxNext = rdIdx;
    modNext   = modReg;
    unique case (state)
      SEQ_IDLE: begin
        if (enterPulse) begin
          if (stackCount == CNT_ZERO) begin
            ctl.popFail = 1'b1;
          end else begin
            stateNext = SEQ_ISSUE;
            rdIdxNext = 2'd0;
          end
        end else if (latchPulse && entryOk) begin
          ctl.pushEntry = 1'b1;
        end
      end
      SEQ_ISSUE: begin
        ctl.readActive = 1'b1;
        ctl.readIdx    = rdIdx;
        stateNext      = SEQ_CAPTURE;
      end
      SEQ_CAPTURE: begin
        ctl.capture = 1'b1;
        ctl.readIdx = rdIdx;
        if (rdIdx == 2'd0) begin
          if ((topIsMod && stackCount >= CNT_TWO) ||
              (!topIsMod && stackCount >= CNT_THREE)) begin
            modNext   = topIsMod;
            rdIdxNext = 2'd1;
            stateNext = SEQ_ISSUE;
          end else begin
            ctl.popFail = 1'b1;
            stateNext   = SEQ_IDLE;
          end
        end else if ((modReg && rdIdx == 2'd1) || rdIdx == 2'd2) begin
          ctl.commitPop = 1'b1;
          ctl.commitMod = modReg;
          stateNext     = SEQ_IDLE;
        end else begin
          rdIdxNext = rdIdx + 2'd1;
          stateNext = SEQ_ISSUE;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SEQ_IDLE;
      rdIdx  <= 2'd0;
      modReg <= 1'b0;
    end else begin
      state  <= stateNext;
      rdIdx  <= rdIdxNext;
      modReg <= modNext;
    end
  end

endmodule

// File: rtl/calc_entry_dp.sv
module calc_entry_dp
  import calc_entry_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyDigitValid,
  input  logic [3:0]    keyDigit,
  input  logic          keyOpValid,
  input  logic [2:0]    keyOpSel,
  input  logic          keyBackspace,
  input  ctlStrobe_t    ctl,
  input  logic [7:0]    ramRData,
  output logic [AW-1:0] ramAddr,
  output logic [7:0]    ramWData,
  output logic          ramWe,
  output logic          aluValid,
  output logic [7:0]    aluOpA,
  output logic [7:0]    aluOpB,
  output logic [7:0]    aluOp,
  output logic          popError,
  output logic [AW:0]   stackCount,
  output logic          entryOk,
  output logic          entryIsNum
);

  localparam logic [11:0] SAT_MAX = 12'd255;

  entKind_t   entKind;
  logic [7:0] entVal;
  logic [11:0] grown;
  logic [7:0] nextNum;
  logic       entReserved;
  logic       opKeyOk, digitKeyOk;
  logic [7:0] slot0, slot1;
  logic [AW:0] readPtr;

  assign grown       = {4'd0, entVal} * 12'd10 + {8'd0, keyDigit};
  assign nextNum     = (grown > SAT_MAX) ? 8'd255 : grown[7:0];
  assign opKeyOk     = keyOpValid && (int'(keyOpSel) < OP_KEYS);
  assign digitKeyOk  = keyDigitValid && (keyDigit <= 4'd9);
  assign entryIsNum  = (entKind == ENT_NUM);
  assign entReserved = entryIsNum && (entVal >= 8'(OP_FIRST)) && (entVal <= 8'(OP_LAST));
  assign entryOk     = (entKind != ENT_EMPTY) && !entReserved && !stackCount[AW];

  assign readPtr  = stackCount - (AW+1)'(1) - (AW+1)'(ctl.readIdx);
  assign ramAddr  = ctl.readActive ? readPtr[AW-1:0] : stackCount[AW-1:0];
  assign ramWData = entVal;
  assign ramWe    = ctl.pushEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entKind <= ENT_EMPTY;
      entVal  <= 8'd0;
    end else if (ctl.pushEntry || keyBackspace) begin
      entKind <= ENT_EMPTY;
      entVal  <= 8'd0;
    end else if (opKeyOk) begin
      entKind <= ENT_OP;
      entVal  <= 8'(OP_FIRST) + {5'd0, keyOpSel};
    end else if (digitKeyOk) begin
      entKind <= ENT_NUM;
      entVal  <= (entKind == ENT_NUM) ? nextNum : {4'd0, keyDigit};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackCount <= '0;
    end else if (ctl.pushEntry) begin
      stackCount <= stackCount + (AW+1)'(1);
    end else if (ctl.commitPop) begin
      stackCount <= stackCount - (ctl.commitMod ? (AW+1)'(2) : (AW+1)'(3));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slot0 <= 8'd0;
      slot1 <= 8'd0;
    end else if (ctl.capture) begin
      if (ctl.readIdx == 2'd0) slot0 <= ramRData;
      if (ctl.readIdx == 2'd1) slot1 <= ramRData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aluValid <= 1'b0;
      popError <= 1'b0;
      aluOpA   <= 8'd0;
      aluOpB   <= 8'd0;
      aluOp    <= 8'd0;
    end else begin
      aluValid <= ctl.commitPop;
      popError <= ctl.popFail;
      if (ctl.commitPop) begin
        aluOpA <= ramRData;
        aluOp  <= ctl.commitMod ? slot0 : slot1;
        aluOpB <= ctl.commitMod ? 8'd0 : slot0;
      end
    end
  end

endmodule

// File: rtl/calc_entry_stack.sv
module calc_entry_stack
  import calc_entry_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyDigitValid,
  input  logic [3:0]    keyDigit,
  input  logic          keyOpValid,
  input  logic [2:0]    keyOpSel,
  input  logic          keyBackspace,
  input  logic          latchPulse,
  input  logic          enterPulse,
  output logic [AW-1:0] ramAddr,
  output logic [7:0]    ramWData,
  output logic          ramWe,
  input  logic [7:0]    ramRData,
  output logic          aluValid,
  output logic [7:0]    aluOpA,
  output logic [7:0]    aluOpB,
  output logic [7:0]    aluOp,
  output logic          popError
);

  ctlStrobe_t ctl;
  logic [AW:0] stackCount;
  logic entryOk;
  logic entryIsNum;

  calc_entry_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .latchPulse (latchPulse),
    .enterPulse (enterPulse),
    .ramRData   (ramRData),
    .stackCount (stackCount),
    .entryOk    (entryOk),
    .ctl        (ctl)
  );

  calc_entry_dp #(.AW(AW)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .keyDigitValid (keyDigitValid),
    .keyDigit      (keyDigit),
    .keyOpValid    (keyOpValid),
    .keyOpSel      (keyOpSel),
    .keyBackspace  (keyBackspace),
    .ctl           (ctl),
    .ramRData      (ramRData),
    .ramAddr       (ramAddr),
    .ramWData      (ramWData),
    .ramWe         (ramWe),
    .aluValid      (aluValid),
    .aluOpA        (aluOpA),
    .aluOpB        (aluOpB),
    .aluOp         (aluOp),
    .popError      (popError),
    .stackCount    (stackCount),
    .entryOk       (entryOk),
    .entryIsNum    (entryIsNum)
  );

endmodule

// File: rtl/calc_entry_chk.sv
module calc_entry_chk #(
  parameter int AW = 13
) (
  input logic        clk,
  input logic        rstN,
  input logic        ramWe,
  input logic [7:0]  ramWData,
  input logic        aluValid,
  input logic [7:0]  aluOpB,
  input logic [7:0]  aluOp,
  input logic        popError,
  input logic [AW:0] stackCount,
  input logic        entryIsNum
);

  p_num_not_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && entryIsNum) |-> (ramWData < 8'd130 || ramWData > 8'd135));

  p_push_grows_r5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |=> (stackCount == $past(stackCount) + (AW+1)'(1)));

  p_no_write_when_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    stackCount[AW] |-> !ramWe);

  p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rstN)
    aluValid |-> (stackCount == $past(stackCount) - (AW+1)'(3) ||
                  stackCount == $past(stackCount) - (AW+1)'(2)));

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    aluValid |=> !aluValid);

  p_mod_b_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (aluValid && aluOp == 8'd133) |-> (aluOpB == 8'd0));

  p_err_keeps_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    popError |-> (stackCount == $past(stackCount)));

  p_err_not_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(aluValid && popError));

endmodule

bind calc_entry_stack calc_entry_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ramWe      (ramWe),
  .ramWData   (ramWData),
  .aluValid   (aluValid),
  .aluOpB     (aluOpB),
  .aluOp      (aluOp),
  .popError   (popError),
  .stackCount (stackCount),
  .entryIsNum (entryIsNum)
);

// File: tb/test_calc_entry_stack.sv
module test_calc_entry_stack;

  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyDigitValid = 1'b0;
  logic [3:0] keyDigit = 4'd0;
  logic keyOpValid = 1'b0;
  logic [2:0] keyOpSel = 3'd0;
  logic keyBackspace = 1'b0;
  logic latchPulse = 1'b0;
  logic enterPulse = 1'b0;
  logic [AW-1:0] ramAddr;
  logic [7:0] ramWData;
  logic ramWe;
  logic [7:0] ramRData = 8'd0;
  logic aluValid;
  logic [7:0] aluOpA, aluOpB, aluOp;
  logic popError;

  logic [7:0] mem [DEPTH];

  always #4 clk = ~clk;

  calc_entry_stack #(.AW(AW)) i_calc_entry_stack (
    .clk(clk), .rstN(rstN),
    .keyDigitValid(keyDigitValid), .keyDigit(keyDigit),
    .keyOpValid(keyOpValid), .keyOpSel(keyOpSel),
    .keyBackspace(keyBackspace), .latchPulse(latchPulse), .enterPulse(enterPulse),
    .ramAddr(ramAddr), .ramWData(ramWData), .ramWe(ramWe), .ramRData(ramRData),
    .aluValid(aluValid), .aluOpA(aluOpA), .aluOpB(aluOpB), .aluOp(aluOp),
    .popError(popError)
  );

  always @(posedge clk) begin
    if (ramWe) mem[ramAddr] <= ramWData;
    ramRData <= mem[ramAddr];
  end

  // reference model state
  int stk[$];
  int entKind = 0;
  int entVal = 0;
  int cnt = 0;
  int kTot = 0;
  bit popIsErr = 0;
  bit popIsMod = 0;
  int expA = 0, expB = 0, expOp = 0;
  bit expValid = 0, expErr = 0;
  int checks = 0, errors = 0;
  string curReq = "R1";

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic bit predPush();
    return latchPulse && cnt == 0 && !enterPulse && entKind != 0 &&
           !(entKind == 1 && entVal >= 130 && entVal <= 135) && stk.size() < DEPTH;
  endfunction

  task automatic firePop();
    if (popIsErr) begin
      expErr = 1;
    end else begin
      expValid = 1;
      if (popIsMod) begin
        expOp = stk.pop_back();
        expA = stk.pop_back();
        expB = 0;
      end else begin
        expB = stk.pop_back();
        expOp = stk.pop_back();
        expA = stk.pop_back();
      end
    end
  endtask

  task automatic step();
    bit p;
    #1;
    p = predPush();
    chk(p ? "R5" : curReq, "ramWe", int'(ramWe), int'(p));
    if (p) begin
      chk("R5", "write address", int'(ramAddr), stk.size() % DEPTH);
      chk("R5", "write data", int'(ramWData), entVal);
    end else if (cnt > 0 && ((kTot - cnt) % 2 == 0)) begin
      chk("R9", "read address", int'(ramAddr), (stk.size() - 1 - (kTot - cnt) / 2) % DEPTH);
    end
    @(posedge clk);
    expValid = 0;
    expErr = 0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) firePop();
    end else if (enterPulse) begin
      if (stk.size() == 0) begin
        expErr = 1;
      end else begin
        if (stk[$] == 133) begin
          popIsMod = 1;
          popIsErr = (stk.size() < 2);
          cnt = popIsErr ? 2 : 4;
        end else begin
          popIsMod = 0;
          popIsErr = (stk.size() < 3);
          cnt = popIsErr ? 2 : 6;
        end
        kTot = cnt;
      end
    end else if (p) begin
      stk.push_back(entVal);
    end
    if (p || keyBackspace) begin
      entKind = 0;
      entVal = 0;
    end else if (keyOpValid && keyOpSel <= 3'd5) begin
      entKind = 2;
      entVal = 130 + int'(keyOpSel);
    end else if (keyDigitValid && keyDigit <= 4'd9) begin
      if (entKind != 1) entVal = int'(keyDigit);
      else entVal = (entVal * 10 + int'(keyDigit) > 255) ? 255 : entVal * 10 + int'(keyDigit);
      entKind = 1;
    end
    @(negedge clk);
    chk(curReq, "aluValid", int'(aluValid), int'(expValid));
    chk(curReq, "popError", int'(popError), int'(expErr));
    chk(curReq, "aluOpA", int'(aluOpA), expA);
    chk(curReq, "aluOpB", int'(aluOpB), expB);
    chk(curReq, "aluOp", int'(aluOp), expOp);
    keyDigitValid = 0;
    keyOpValid = 0;
    keyBackspace = 0;
    latchPulse = 0;
    enterPulse = 0;
  endtask

  task automatic typeNum(string s);
    for (int i = 0; i < s.len(); i++) begin
      keyDigitValid = 1;
      keyDigit = 4'(s[i] - 8'd48);
      step();
    end
  endtask

  task automatic rawDigit(int d);
    keyDigitValid = 1;
    keyDigit = 4'(d);
    step();
  endtask

  task automatic pressOp(int sel);
    keyOpValid = 1;
    keyOpSel = 3'(sel);
    step();
  endtask

  task automatic latchIt();
    latchPulse = 1;
    step();
  endtask

  task automatic backspace();
    keyBackspace = 1;
    step();
  endtask

  task automatic enterIt();
    enterPulse = 1;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pushNum(string s);
    typeNum(s);
    latchIt();
  endtask

  task automatic pushOp(int sel);
    pressOp(sel);
    latchIt();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'd0;
    repeat (3) @(negedge clk);
    curReq = "R1";
    chk("R1", "aluValid in reset", int'(aluValid), 0);
    chk("R1", "popError in reset", int'(popError), 0);
    chk("R1", "ramWe in reset", int'(ramWe), 0);
    chk("R1", "aluOpA in reset", int'(aluOpA), 0);
    chk("R1", "ramAddr in reset", int'(ramAddr), 0);
    rstN = 1;
    idle(3);

    curReq = "R8";
    enterIt();
    idle(2);

    curReq = "R2";
    typeNum("98");
    rawDigit(12);
    latchIt();
    curReq = "R3";
    pushOp(0);
    curReq = "R2";
    pushNum("010");

    curReq = "R6";
    enterIt();
    idle(8);

    curReq = "R3";
    typeNum("132");
    latchIt();
    idle(1);
    curReq = "R4";
    backspace();
    latchIt();
    curReq = "R2";
    pushNum("007");
    curReq = "R3";
    pushOp(2);
    pressOp(6);
    latchIt();
    curReq = "R2";
    pushNum("7");
    pushNum("1234");
    curReq = "R3";
    pushOp(3);

    curReq = "R7";
    enterIt();
    idle(6);

    curReq = "R10";
    enterIt();
    typeNum("5");
    latchIt();
    enterIt();
    idle(6);
    curReq = "R11";
    latchIt();
    pushOp(1);
    pushNum("30");
    enterIt();
    idle(8);

    curReq = "R8";
    pushNum("6");
    enterIt();
    idle(4);
    pushOp(3);
    curReq = "R7";
    enterIt();
    idle(6);
    curReq = "R8";
    pushOp(3);
    enterIt();
    idle(4);
    pushNum("9");
    enterIt();
    idle(4);

    curReq = "R5";
    for (int i = 0; i < 8; i++) pushNum("1");
    pushNum("2");
    curReq = "R10";
    typeNum("3");
    latchPulse = 1;
    enterPulse = 1;
    step();
    idle(8);
    curReq = "R9";
    enterIt();
    idle(8);
    curReq = "R11";
    pushNum("4");
    pushOp(4);
    enterIt();
    idle(8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule